// File: doc/BRIEF.md
# Reservation Flag Store-Conditional Gate

This block sits beside a processor core and keeps one reservation flag on its behalf. A load-and-reserve from the core sets the flag. A cancel line driven by outside reservation logic, sampled on each rising clock edge, clears it. Each store-conditional from the core is decided against the flag before any bus activity begins.

When the flag is set, the block raises a one-cycle start pulse that launches the external write cycle. When the flag is clear, no start pulse is given, so the bus never sees the access. In both cases the core receives a one-cycle status pulse that carries a success bit. Every store-conditional uses up the reservation, whether it succeeds or fails. Address matching and the bus protocol that follows the start pulse are handled elsewhere.

Top module: `rsv_gate`

## Requirements
- R1: A synchronous active-high reset clears the flag and drives `ext_start`, `stat_valid` and `stat_ok` low. A store-conditional issued after reset, with no reserve in between, fails.
- R2: A cycle with `reserve_req` high and neither `cancel_in` nor `stcx_req` high sets the flag.
- R3: A cycle with `cancel_in` sampled high clears the flag.
- R4: When `reserve_req` and `cancel_in` are high in the same cycle, the cancel wins and the flag ends up clear.
- R5: When `stcx_req` is high in cycle t and the flag is set, `ext_start`, `stat_valid` and `stat_ok` are all 1 in cycle t+1.
- R6: When `stcx_req` is high in cycle t and the flag is clear, `stat_valid` is 1, `stat_ok` is 0 and `ext_start` is 0 in cycle t+1.
- R7: When `cancel_in` is high in the same cycle as `stcx_req`, the store-conditional fails and no start pulse is given.
- R8: A store-conditional clears the flag, so a second store-conditional with no reserve in between fails.
- R9: A reserve in the same cycle as a store-conditional has no effect. The decision uses the flag as it stood before that cycle, and the flag is clear afterwards.
- R10: The outputs are single-cycle pulses. `stat_ok` is never 1 unless `stat_valid` is 1, and `ext_start` equals `stat_valid` AND `stat_ok`.
- R11: No output pulse appears in a cycle that does not follow a `stcx_req`. Idle cycles leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reserve_req | input | 1 | Load-and-reserve from the core; sets the flag |
| stcx_req | input | 1 | Store-conditional request from the core |
| cancel_in | input | 1 | Reservation cancel from outside reservation logic |
| ext_start | output | 1 | One-cycle pulse that launches the external write cycle |
| stat_valid | output | 1 | One-cycle pulse: a store-conditional decision is reported |
| stat_ok | output | 1 | Success bit, meaningful while `stat_valid` is 1 |

## Verification
The store-conditional decision is tested from four starting points: after a clean reserve, after a cancel, after an earlier store-conditional has used the reservation, and after a reset. Together these show that the flag is set only by a reserve, and cleared by a cancel, a consuming store or a reset. Inputs that arrive in the same cycle (reserve with cancel, cancel with store, reserve with store) separate the priority order from simple sequencing, and show that the decision reads the flag as it stood before that cycle. Idle cycles between operations check that the flag holds its value and that no output pulses appear.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        FLAG_HOLD = 2'd0,
        FLAG_SET  = 2'd1,
        FLAG_CLR  = 2'd2
    } flag_op_t;

    typedef struct packed {
        logic start;
        logic valid;
        logic ok;
    } rsv_result_t;

    localparam rsv_result_t RESULT_IDLE = '{start: 1'b0, valid: 1'b0, ok: 1'b0};

    // Priority order: cancel, then consumption by a store-conditional, then reserve.
    function automatic flag_op_t pick_flag_op(input logic cancel,
                                              input logic stcx,
                                              input logic reserve);
        flag_op_t op;
        if (cancel || stcx)
            op = FLAG_CLR;
        else if (reserve)
            op = FLAG_SET;
        else
            op = FLAG_HOLD;
        return op;
    endfunction

    function automatic rsv_result_t decide(input logic stcx,
                                           input logic flag_live);
        rsv_result_t r;
        r.valid = stcx;
        r.ok    = stcx && flag_live;
        r.start = stcx && flag_live;
        return r;
    endfunction

endpackage

// File: rtl/rsv_flag_cell.sv
module rsv_flag_cell
    import rsv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  flag_op_t op,
    output logic     flag_q
);

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else begin
            unique case (op)
                FLAG_SET: flag_q <= 1'b1;
                FLAG_CLR: flag_q <= 1'b0;
                default:  flag_q <= flag_q;
            endcase
        end
    end

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (op == FLAG_CLR) |=> !flag_q); // R3

    AST_SET_FILLS: assert property (@(posedge clk) disable iff (rst)
        (op == FLAG_SET) |=> flag_q); // R2

endmodule

// File: rtl/rsv_decide.sv
module rsv_decide
    import rsv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        stcx_req,
    input  logic        cancel_in,
    input  logic        flag_q,
    output rsv_result_t result_q
);

    logic        flag_live;
    rsv_result_t result_d;

    // A cancel sampled on the same edge as the store-conditional wins.
    assign flag_live = flag_q && !cancel_in;
    assign result_d  = decide(stcx_req, flag_live);

    always_ff @(posedge clk) begin
        if (rst)
            result_q <= RESULT_IDLE;
        else
            result_q <= result_d;
    end

    AST_CANCEL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (stcx_req && cancel_in) |=> !result_q.start); // R7

    AST_EMPTY_FLAG_FAILS: assert property (@(posedge clk) disable iff (rst)
        (stcx_req && !flag_q) |=> (result_q.valid && !result_q.ok)); // R6

    AST_NO_REQ_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        !stcx_req |=> !result_q.valid); // R11

endmodule

// File: rtl/rsv_gate.sv
module rsv_gate
    import rsv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic reserve_req,
    input  logic stcx_req,
    input  logic cancel_in,
    output logic ext_start,
    output logic stat_valid,
    output logic stat_ok
);

    flag_op_t    flag_op;
    logic        flag_q;
    rsv_result_t result_q;

    assign flag_op = pick_flag_op(cancel_in, stcx_req, reserve_req);

    rsv_flag_cell u_flag (
        .clk    (clk),
        .rst    (rst),
        .op     (flag_op),
        .flag_q (flag_q)
    );

    rsv_decide u_decide (
        .clk       (clk),
        .rst       (rst),
        .stcx_req  (stcx_req),
        .cancel_in (cancel_in),
        .flag_q    (flag_q),
        .result_q  (result_q)
    );

    assign ext_start  = result_q.start;
    assign stat_valid = result_q.valid;
    assign stat_ok    = result_q.ok;

    AST_OK_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        stat_ok |-> stat_valid); // R10

    AST_START_IS_SUCCESS: assert property (@(posedge clk) disable iff (rst)
        ext_start == (stat_valid && stat_ok)); // R10

    AST_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        stcx_req |=> !flag_q); // R8

    AST_RESERVE_SUCCESS: assert property (@(posedge clk) disable iff (rst)
        (stcx_req && flag_q && !cancel_in) |=> (ext_start && stat_ok)); // R5

endmodule

// File: tb/test_rsv_gate.sv
module test_rsv_gate;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reserve_req = 1'b0;
    logic stcx_req = 1'b0;
    logic cancel_in = 1'b0;
    logic ext_start, stat_valid, stat_ok;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rsv_gate i_rsv_gate (
        .clk         (clk),
        .rst         (rst),
        .reserve_req (reserve_req),
        .stcx_req    (stcx_req),
        .cancel_in   (cancel_in),
        .ext_start   (ext_start),
        .stat_valid  (stat_valid),
        .stat_ok     (stat_ok)
    );

    // {reserve, stcx, cancel, exp_start, exp_valid, exp_ok}
    localparam int NV = 20;
    localparam logic [5:0] VEC [NV] = '{
        6'b010_010, // R6 fresh flag is clear
        6'b100_000, // R2 reserve
        6'b010_111, // R5 success
        6'b010_010, // R8 consumed
        6'b100_000, // R2 reserve
        6'b001_000, // R3 cancel
        6'b010_010, // R3 fails after cancel
        6'b101_000, // R4 reserve with cancel
        6'b010_010, // R4 cancel won
        6'b100_000, // R2 reserve
        6'b011_010, // R7 cancel with store
        6'b010_010, // R7 flag also gone
        6'b100_000, // R2 reserve
        6'b110_111, // R9 prior flag decides
        6'b010_010, // R9 reserve ignored
        6'b110_010, // R9 clear flag, reserve ignored
        6'b010_010, // R9 still clear
        6'b100_000, // R2 reserve
        6'b000_000, // R11 idle holds
        6'b010_111  // R11 flag held over idle
    };
    localparam string TAG [NV] = '{
        "R6", "R2", "R5", "R8", "R2", "R3", "R3", "R4", "R4", "R2",
        "R7", "R7", "R2", "R9", "R9", "R9", "R9", "R2", "R11", "R11"
    };

    task automatic check(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {ext_start, stat_valid, stat_ok};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: start/valid/ok actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic s, input logic c);
        reserve_req = r;
        stcx_req    = s;
        cancel_in   = c;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 3'b000);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][5], VEC[i][4], VEC[i][3]);
            @(negedge clk);
            check(TAG[i], VEC[i][2:0]);
        end
        drive(0, 0, 0);
        @(negedge clk);
        check("R10", 3'b000);

        // Reset clears a live reservation.
        drive(1, 0, 0);
        @(negedge clk);
        drive(0, 0, 0);
        rst = 1'b1;
        @(negedge clk);
        check("R1", 3'b000);
        rst = 1'b0;
        drive(0, 1, 0);
        @(negedge clk);
        check("R1", 3'b010);

        // Reset during a store-conditional request gives no pulse.
        drive(1, 0, 0);
        @(negedge clk);
        drive(0, 1, 0);
        rst = 1'b1;
        @(negedge clk);
        check("R1", 3'b000);
        rst = 1'b0;
        drive(0, 0, 0);
        @(negedge clk);
        check("R11", 3'b000);

        // Back-to-back success pulse lasts one cycle.
        drive(1, 0, 0);
        @(negedge clk);
        drive(0, 1, 0);
        @(negedge clk);
        check("R5", 3'b111);
        drive(0, 0, 0);
        @(negedge clk);
        check("R10", 3'b000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule